// File: doc/BRIEF.md
# Stream-to-Buffer Descriptor Builder

The block takes an AXI4-Stream of outbound user data and lays it down, beat by beat, into a ring of eight fixed-size buffers of 4096 bytes. The buffers sit in a block memory that a DMA engine reads later over its own memory-mapped port. The block drives the write side of that memory. A buffer is closed by one of two events, whichever comes first: it holds 4096 bytes, or a beat carrying TLAST arrives. When a buffer closes, the block issues a one-cycle source descriptor to the DMA. The descriptor carries the byte address where the buffer starts, the number of valid bytes, and whether a packet ends there. The next beat goes straight into the next buffer in ring order, so a long stream turns into a steady run of descriptors.

The DMA returns each buffer once it has read it out, by naming the buffer's index on a release strobe. Releases must come oldest first. A release that names any other buffer, or that arrives when nothing is outstanding, changes nothing and raises a one-cycle error pulse. When all eight buffers are closed and not yet released, the block withholds TREADY, so no unread buffer is ever overwritten.

Top module: `stream_desc_builder`

## Requirements
- R1: After reset, `s_tready` is 1 and `desc_valid`, `rel_err` and `mem_we` are 0, and the first beat goes to byte address 0.
- R2: Every accepted beat (`s_tvalid` and `s_tready`) drives `mem_we`=1 in that same cycle. It presents `s_tdata` and `s_tkeep` on `mem_wdata` and `mem_wstrb`, with `mem_addr` = buffer index × 4096 + bytes already written to that buffer. Bit i of TKEEP qualifies byte lane `data[8i+7:8i]`.
- R3: A buffer that reaches 4096 bytes without TLAST produces, in the cycle after its last beat, a single-cycle `desc_valid` with `desc_bytes`=4096 and `desc_eop`=0.
- R4: A beat with TLAST closes the buffer. In the next cycle the descriptor shows `desc_eop`=1 and `desc_bytes` = 8 bytes for each earlier beat in the buffer plus the number of set TKEEP bits on the TLAST beat. TKEEP is taken as contiguous from bit 0. When TLAST lands on the beat that fills the buffer, the count is 4096 and `desc_eop`=1.
- R5: Buffers are used in ring order 0,1,…,7,0. `desc_addr` is index × 4096. The beat after a closing beat may be accepted in the very next cycle and is written at offset 0 of the next buffer.
- R6: While eight closed buffers are unreleased, `s_tready` is 0 and no write is issued.
- R7: A release whose `rel_idx` equals the oldest unreleased buffer frees that buffer: `rel_err` stays 0, and if the block was stalled, `s_tready` is 1 in the next cycle.
- R8: A release naming any other buffer pulses `rel_err` for exactly one cycle, in the cycle after the strobe, and frees nothing (a stalled block stays stalled).
- R9: A buffer close and a valid release in the same cycle are both honoured. The outstanding count is unchanged, and the descriptor and release bookkeeping each advance by one.
- R10: A release while no buffer is outstanding pulses `rel_err` for one cycle and has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | DATA_W (64) | Stream data |
| s_tkeep | input | DATA_W/8 (8) | Byte qualifiers, contiguous from bit 0 |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Last beat of a packet |
| s_tready | output | 1 | Beat accepted when high with `s_tvalid` |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | 15 | Byte address of the written beat |
| mem_wdata | output | DATA_W (64) | Write data |
| mem_wstrb | output | DATA_W/8 (8) | Write byte strobes |
| desc_valid | output | 1 | Descriptor strobe, one cycle per closed buffer |
| desc_addr | output | 15 | Start byte address of the closed buffer |
| desc_bytes | output | 13 | Valid bytes in the closed buffer (1..4096) |
| desc_eop | output | 1 | Buffer was closed by TLAST |
| rel_valid | input | 1 | Buffer release strobe from the DMA |
| rel_idx | input | 3 | Index of the buffer being released |
| rel_err | output | 1 | One-cycle pulse after an out-of-order or surplus release |

## Verification
The two functions that can collide are the closing of a buffer, which adds to the outstanding count, and a DMA release, which subtracts from it. The bench first brings the ring to seven outstanding buffers. It then drives a single-beat TLAST packet and an in-order release on the same clock edge. It judges the result from the ports alone: the descriptor appears with the wrapped address 0 and no error, TREADY stays high, and exactly one more closing beat then stalls the stream. A lost or double-counted update shows up as a wrong stall point. The same approach covers a bad release while stalled, where TREADY must stay low.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    localparam int unsigned DEF_NUM_BUF   = 8;
    localparam int unsigned DEF_BUF_BYTES = 4096;
    localparam int unsigned DEF_DATA_W    = 64;

    // Number of set qualifier bits; lanes beyond the stream width are zero.
    function automatic logic [7:0] lane_count(input logic [63:0] keep);
        logic [7:0] n;
        n = '0;
        for (int i = 0; i < 64; i++) begin
            n = n + 8'(keep[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/sdb_pool.sv
module sdb_pool #(
    parameter  int unsigned NUM_BUF = sdb_pkg::DEF_NUM_BUF,
    localparam int unsigned IDX_W   = $clog2(NUM_BUF),
    localparam int unsigned OCC_W   = $clog2(NUM_BUF + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close_i,
    input  logic             rel_valid_i,
    input  logic [IDX_W-1:0] rel_idx_i,
    output logic [IDX_W-1:0] wr_ptr_o,
    output logic [IDX_W-1:0] rel_ptr_o,
    output logic [OCC_W-1:0] occ_o,
    output logic             full_o,
    output logic             rel_err_o
);

    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
    localparam logic [OCC_W-1:0] OCC_ONE  = OCC_W'(1);
    localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(NUM_BUF);

    typedef struct packed {
        logic [IDX_W-1:0] wr_ptr;
        logic [IDX_W-1:0] rel_ptr;
        logic [OCC_W-1:0] occ;
        logic             rel_err;
    } pool_t;

    pool_t pool_d, pool_q;
    logic  rel_ok;

    always_comb begin
        pool_d = pool_q;
        rel_ok = rel_valid_i && (pool_q.occ != '0) && (rel_idx_i == pool_q.rel_ptr);
        pool_d.rel_err = rel_valid_i && !rel_ok;
        if (close_i) begin
            pool_d.wr_ptr = pool_q.wr_ptr + IDX_ONE;
        end
        if (rel_ok) begin
            pool_d.rel_ptr = pool_q.rel_ptr + IDX_ONE;
        end
        case ({close_i, rel_ok})
            2'b10:   pool_d.occ = pool_q.occ + OCC_ONE;
            2'b01:   pool_d.occ = pool_q.occ - OCC_ONE;
            default: pool_d.occ = pool_q.occ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pool_q <= '0;
        end else begin
            pool_q <= pool_d;
        end
    end

    assign wr_ptr_o  = pool_q.wr_ptr;
    assign rel_ptr_o = pool_q.rel_ptr;
    assign occ_o     = pool_q.occ;
    assign full_o    = (pool_q.occ == OCC_FULL);
    assign rel_err_o = pool_q.rel_err;

endmodule

// File: rtl/sdb_fill.sv
module sdb_fill #(
    parameter  int unsigned NUM_BUF   = sdb_pkg::DEF_NUM_BUF,
    parameter  int unsigned BUF_BYTES = sdb_pkg::DEF_BUF_BYTES,
    parameter  int unsigned DATA_W    = sdb_pkg::DEF_DATA_W,
    localparam int unsigned IDX_W     = $clog2(NUM_BUF),
    localparam int unsigned OFF_W     = $clog2(BUF_BYTES),
    localparam int unsigned CNT_W     = OFF_W + 1,
    localparam int unsigned ADDR_W    = IDX_W + OFF_W,
    localparam int unsigned KEEP_W    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_i,
    input  logic              last_i,
    input  logic [KEEP_W-1:0] keep_i,
    input  logic [IDX_W-1:0]  wr_ptr_i,
    output logic              close_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              desc_valid_o,
    output logic [ADDR_W-1:0] desc_addr_o,
    output logic [CNT_W-1:0]  desc_bytes_o,
    output logic              desc_eop_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUF_BYTES);
    localparam logic [CNT_W-1:0] BEAT_CNT = CNT_W'(KEEP_W);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              dv;
        logic [ADDR_W-1:0] daddr;
        logic [CNT_W-1:0]  dbytes;
        logic              deop;
    } fill_t;

    fill_t            fill_d, fill_q;
    logic [CNT_W-1:0] beat_bytes;
    logic [CNT_W-1:0] new_cnt;
    logic             close;

    always_comb begin
        fill_d     = fill_q;
        beat_bytes = last_i ? CNT_W'(sdb_pkg::lane_count(64'(keep_i))) : BEAT_CNT;
        new_cnt    = fill_q.cnt + beat_bytes;
        close      = beat_i && (last_i || (new_cnt == CNT_FULL));
        fill_d.dv  = close;
        if (close) begin
            fill_d.daddr  = {wr_ptr_i, {OFF_W{1'b0}}};
            fill_d.dbytes = new_cnt;
            fill_d.deop   = last_i;
            fill_d.cnt    = '0;
        end else if (beat_i) begin
            fill_d.cnt    = new_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end

    assign close_o      = close;
    assign mem_addr_o   = {wr_ptr_i, fill_q.cnt[OFF_W-1:0]};
    assign desc_valid_o = fill_q.dv;
    assign desc_addr_o  = fill_q.daddr;
    assign desc_bytes_o = fill_q.dbytes;
    assign desc_eop_o   = fill_q.deop;

endmodule

// File: rtl/stream_desc_builder.sv
module stream_desc_builder #(
    parameter  int unsigned NUM_BUF   = sdb_pkg::DEF_NUM_BUF,
    parameter  int unsigned BUF_BYTES = sdb_pkg::DEF_BUF_BYTES,
    parameter  int unsigned DATA_W    = sdb_pkg::DEF_DATA_W,
    localparam int unsigned IDX_W     = $clog2(NUM_BUF),
    localparam int unsigned OFF_W     = $clog2(BUF_BYTES),
    localparam int unsigned CNT_W     = OFF_W + 1,
    localparam int unsigned ADDR_W    = IDX_W + OFF_W,
    localparam int unsigned KEEP_W    = DATA_W / 8,
    localparam int unsigned OCC_W     = $clog2(NUM_BUF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [KEEP_W-1:0] s_tkeep,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [KEEP_W-1:0] mem_wstrb,
    output logic              desc_valid,
    output logic [ADDR_W-1:0] desc_addr,
    output logic [CNT_W-1:0]  desc_bytes,
    output logic              desc_eop,
    input  logic              rel_valid,
    input  logic [IDX_W-1:0]  rel_idx,
    output logic              rel_err
);

    logic             accept;
    logic             close;
    logic             full;
    logic [IDX_W-1:0] wr_ptr;
    logic [IDX_W-1:0] rel_ptr;
    logic [OCC_W-1:0] occ;

    assign s_tready  = !full;
    assign accept    = s_tvalid && !full;
    assign mem_we    = accept;
    assign mem_wdata = s_tdata;
    assign mem_wstrb = s_tkeep;

    sdb_fill #(
        .NUM_BUF   (NUM_BUF),
        .BUF_BYTES (BUF_BYTES),
        .DATA_W    (DATA_W)
    ) i_fill (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_i       (accept),
        .last_i       (s_tlast),
        .keep_i       (s_tkeep),
        .wr_ptr_i     (wr_ptr),
        .close_o      (close),
        .mem_addr_o   (mem_addr),
        .desc_valid_o (desc_valid),
        .desc_addr_o  (desc_addr),
        .desc_bytes_o (desc_bytes),
        .desc_eop_o   (desc_eop)
    );

    sdb_pool #(
        .NUM_BUF (NUM_BUF)
    ) i_pool (
        .clk         (clk),
        .rst_n       (rst_n),
        .close_i     (close),
        .rel_valid_i (rel_valid),
        .rel_idx_i   (rel_idx),
        .wr_ptr_o    (wr_ptr),
        .rel_ptr_o   (rel_ptr),
        .occ_o       (occ),
        .full_o      (full),
        .rel_err_o   (rel_err)
    );

endmodule

// File: rtl/sdb_checker.sv
module sdb_checker #(
    parameter  int unsigned NUM_BUF   = sdb_pkg::DEF_NUM_BUF,
    parameter  int unsigned BUF_BYTES = sdb_pkg::DEF_BUF_BYTES,
    localparam int unsigned IDX_W     = $clog2(NUM_BUF),
    localparam int unsigned CNT_W     = $clog2(BUF_BYTES) + 1,
    localparam int unsigned OCC_W     = $clog2(NUM_BUF + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_tvalid,
    input logic             s_tlast,
    input logic             s_tready,
    input logic             mem_we,
    input logic             desc_valid,
    input logic [CNT_W-1:0] desc_bytes,
    input logic             desc_eop,
    input logic             rel_valid,
    input logic [IDX_W-1:0] rel_idx,
    input logic             rel_err,
    input logic [IDX_W-1:0] wr_ptr,
    input logic [IDX_W-1:0] rel_ptr,
    input logic [OCC_W-1:0] occ
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUF_BYTES);
    localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(NUM_BUF);

    p_full_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_FULL) |-> (!s_tready && !mem_we));

    p_occ_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_FULL);

    p_ring_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr == IDX_W'(rel_ptr + occ[IDX_W-1:0]));

    p_full_desc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_eop) |-> (desc_bytes == CNT_FULL));

    p_size_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_bytes <= CNT_FULL));

    p_last_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready && s_tlast) |=> (desc_valid && desc_eop));

    p_bad_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && (occ == '0 || rel_idx != rel_ptr)) |=> rel_err);

    p_good_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && occ != '0 && rel_idx == rel_ptr) |=> !rel_err);

    p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_valid |=> !rel_err);

endmodule

bind stream_desc_builder sdb_checker #(
    .NUM_BUF   (NUM_BUF),
    .BUF_BYTES (BUF_BYTES)
) i_sdb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_tvalid   (s_tvalid),
    .s_tlast    (s_tlast),
    .s_tready   (s_tready),
    .mem_we     (mem_we),
    .desc_valid (desc_valid),
    .desc_bytes (desc_bytes),
    .desc_eop   (desc_eop),
    .rel_valid  (rel_valid),
    .rel_idx    (rel_idx),
    .rel_err    (rel_err),
    .wr_ptr     (wr_ptr),
    .rel_ptr    (rel_ptr),
    .occ        (occ)
);

// File: tb/test_stream_desc_builder.sv
`timescale 1ns/100ps
module test_stream_desc_builder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] s_tdata = '0;
    logic [7:0]  s_tkeep = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic        mem_we;
    logic [14:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_wstrb;
    logic        desc_valid;
    logic [14:0] desc_addr;
    logic [12:0] desc_bytes;
    logic        desc_eop;
    logic        rel_valid = 1'b0;
    logic [2:0]  rel_idx = '0;
    logic        rel_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model
    int m_buf = 0;
    int m_off = 0;
    int m_occ = 0;
    int m_rel = 0;
    int m_seq = 0;

    always #2.5 clk = ~clk;

    stream_desc_builder i_stream_desc_builder (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_tdata    (s_tdata),
        .s_tkeep    (s_tkeep),
        .s_tvalid   (s_tvalid),
        .s_tlast    (s_tlast),
        .s_tready   (s_tready),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_wstrb  (mem_wstrb),
        .desc_valid (desc_valid),
        .desc_addr  (desc_addr),
        .desc_bytes (desc_bytes),
        .desc_eop   (desc_eop),
        .rel_valid  (rel_valid),
        .rel_idx    (rel_idx),
        .rel_err    (rel_err)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one accepted beat; returns at the following falling edge.
    task automatic send_beat(input logic last, input logic [7:0] keep, input string req);
        int add;
        m_seq++;
        s_tvalid = 1'b1;
        s_tlast  = last;
        s_tkeep  = keep;
        s_tdata  = {32'(m_seq), 32'(m_seq * 3)};
        #1;
        chk("R2", "mem_we", mem_we, 1);
        chk("R2", "mem_addr", mem_addr, m_buf * 4096 + m_off);
        chk("R2", "mem_wdata", mem_wdata, s_tdata);
        chk("R2", "mem_wstrb", mem_wstrb, keep);
        @(posedge clk);
        @(negedge clk);
        add = last ? $countones(keep) : 8;
        m_off += add;
        if (last || m_off == 4096) begin
            chk(req, "desc_valid", desc_valid, 1);
            chk(req, "desc_addr", desc_addr, m_buf * 4096);
            chk(req, "desc_bytes", desc_bytes, m_off);
            chk(req, "desc_eop", desc_eop, last);
            m_buf = (m_buf + 1) % 8;
            m_off = 0;
            m_occ++;
        end else begin
            chk(req, "desc_valid idle", desc_valid, 0);
        end
    endtask

    task automatic idle();
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
        s_tkeep  = '0;
    endtask

    task automatic release_buf(input int idx);
        rel_valid = 1'b1;
        rel_idx   = 3'(idx);
        @(posedge clk);
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "s_tready", s_tready, 1);
        chk("R1", "desc_valid", desc_valid, 0);
        chk("R1", "rel_err", rel_err, 0);
        chk("R1", "mem_we", mem_we, 0);
    endtask

    task automatic t_short_packet();
        send_beat(1'b0, 8'hFF, "R4");
        send_beat(1'b0, 8'hFF, "R4");
        send_beat(1'b1, 8'h07, "R4");   // 8+8+3 = 19 bytes, buffer 0
        idle();
    endtask

    task automatic t_single_byte();
        send_beat(1'b1, 8'h01, "R4");   // 1 byte, buffer 1
        idle();
    endtask

    task automatic t_full_then_continue();
        for (int i = 0; i < 512; i++) begin
            send_beat(1'b0, 8'hFF, "R3");
        end
        chk("R5", "s_tready after close", s_tready, 1);
        // next beat in the very next cycle, offset 0 of buffer 3
        send_beat(1'b0, 8'hFF, "R5");
        send_beat(1'b1, 8'hFF, "R5");
        idle();
    endtask

    task automatic t_full_with_last();
        for (int i = 0; i < 511; i++) begin
            send_beat(1'b0, 8'hFF, "R4");
        end
        send_beat(1'b1, 8'hFF, "R4");   // 4096 bytes with eop
        idle();
    endtask

    task automatic t_fill_to_stall();
        send_beat(1'b1, 8'h03, "R5");
        send_beat(1'b1, 8'h0F, "R5");
        send_beat(1'b1, 8'h3F, "R5");
        idle();
        chk("R6", "s_tready all outstanding", s_tready, 0);
        s_tvalid = 1'b1;
        s_tlast  = 1'b1;
        s_tkeep  = 8'h01;
        #1;
        chk("R6", "mem_we while stalled", mem_we, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R6", "desc_valid while stalled", desc_valid, 0);
        chk("R6", "s_tready still low", s_tready, 0);
        idle();
    endtask

    task automatic t_bad_release();
        release_buf(3);
        chk("R8", "rel_err pulse", rel_err, 1);
        chk("R8", "s_tready unchanged", s_tready, 0);
        @(negedge clk);
        chk("R8", "rel_err one cycle", rel_err, 0);
        chk("R8", "still stalled", s_tready, 0);
    endtask

    task automatic t_good_release();
        release_buf(m_rel);
        m_rel = (m_rel + 1) % 8;
        m_occ--;
        chk("R7", "rel_err", rel_err, 0);
        chk("R7", "s_tready freed", s_tready, 1);
    endtask

    task automatic t_close_and_release();
        // seven outstanding; close buffer 0 and release buffer 1 on the same edge
        rel_valid = 1'b1;
        rel_idx   = 3'(m_rel);
        send_beat(1'b1, 8'h0F, "R9");
        rel_valid = 1'b0;
        m_rel = (m_rel + 1) % 8;
        m_occ--;
        chk("R9", "rel_err", rel_err, 0);
        chk("R9", "s_tready count unchanged", s_tready, 1);
        send_beat(1'b1, 8'h01, "R9");
        idle();
        chk("R9", "stall after one more close", s_tready, 0);
    endtask

    task automatic t_drain_and_underflow();
        for (int i = 0; i < 8; i++) begin
            release_buf(m_rel);
            m_rel = (m_rel + 1) % 8;
            m_occ--;
            chk("R7", "drain rel_err", rel_err, 0);
            chk("R7", "drain s_tready", s_tready, 1);
        end
        release_buf(m_rel);
        chk("R10", "rel_err on empty pool", rel_err, 1);
        @(negedge clk);
        chk("R10", "rel_err cleared", rel_err, 0);
        // pool unchanged: next packet still goes to the expected buffer
        send_beat(1'b1, 8'hFF, "R10");
        idle();
    endtask

    initial begin
        t_reset();
        t_short_packet();
        t_single_byte();
        t_full_then_continue();
        t_full_with_last();
        t_fill_to_stall();
        t_bad_release();
        t_good_release();
        t_close_and_release();
        t_drain_and_underflow();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule